// File: doc/BRIEF.md
# SPI MRAM Access Controller

This block is a bus master for a serial magnetoresistive RAM attached over SPI. A local client presents a request made of an operation code, a byte address and a byte count. The controller first checks the request against the device capacity and, if it fits, runs the matching SPI transaction. Write data comes in on a byte-wide valid/ready stream, and read data goes out on another one.

A write takes two chip-select frames. The first carries only the write-enable opcode. The second carries the write opcode, the address and the payload. A read takes a single frame: the read opcode and the address, followed by as many clocked-in bytes as were asked for. The device needs no erase. An erase request is therefore only range-checked and answered, and the serial bus is never touched for it.

The SCK rate comes from the system clock through a parameterised half-period divider. Chip select always stays high for at least one full SCK period between frames. While a request is in progress `busy` is high, and each request ends with a one-cycle `done` pulse whose `done_ok` qualifier gives the outcome.

Top module: `spi_mram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `spi_cs_n` is 1 and `spi_sck`, `busy`, `done`, `rd_valid` and `wr_ready` are all 0.
- R2: A read (`req_op`=0) or write (`req_op`=1) is refused when the address is at or beyond the capacity (524288 bytes by default), or when address plus length exceeds it. A refused request gives `done` with `done_ok`=0 and `spi_cs_n` never falls for it.
- R3: An erase (`req_op`=2) gives `done_ok`=1 exactly when the 256-byte block starting at the address lies inside the capacity, and `done_ok`=0 otherwise. It never lowers `spi_cs_n`.
- R4: An accepted write runs a frame holding the single byte 0x06, then a second frame holding 0x02, the three address bytes (most significant first) and the payload bytes in stream order.
- R5: An accepted read runs one frame holding 0x03 and the three address bytes (most significant first), then shifts out 0x00 once per requested byte. The bytes sampled on MISO, MSB first, are delivered on `rd_data` in order. A length of 0 sends only the command and address.
- R6: SPI mode 0. `spi_sck` is low whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sck` is low. MISO is sampled on the rising SCK edge.
- R7: Every SCK high phase lasts exactly `SCK_HALF` system clocks (2 by default).
- R8: Between a rising and the next falling edge of `spi_cs_n`, at least 2×`SCK_HALF` system clocks pass.
- R9: A request is taken when `req_valid` is high and `busy` is low. Requests raised while `busy` is high are ignored. `done` lasts one cycle, with `busy` low. A request held in the `done` cycle is taken on the next edge.
- R10: `wr_ready` is high only inside a frame, while the controller waits for a payload byte. Once `rd_valid` is high, it and `rd_data` hold until `rd_ready`, and SCK stays idle meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 erase |
| req_addr | input | 24 | Start byte address |
| req_len | input | 16 | Byte count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Outcome of the last request, valid with `done` |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Payload byte available |
| wr_ready | output | 1 | Controller takes payload byte |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes read byte |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The `done` pulse of one request and the acceptance of the next can fall in the same cycle. To provoke this, the bench holds `req_valid` high through a whole write and changes the request fields to a read in the cycle where `done` is seen. It judges the result by requiring `busy` high and `done` low in the next cycle. Both frames must then appear on the bus in order, with the read data intact. A second pairing is a request strobe raised in the middle of a read under read-stream backpressure. The bench requires that it yields no extra `done` and leaves the frame bytes unchanged.

// File: rtl/spi_mram_pkg.sv
package spi_mram_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } mram_op_e;

  localparam logic [7:0] CMD_WR_ENABLE = 8'h06;
  localparam logic [7:0] CMD_READ      = 8'h03;
  localparam logic [7:0] CMD_WRITE     = 8'h02;
  localparam logic [7:0] RD_FILLER     = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FIN,
    S_WREN,
    S_GAP,
    S_CMD,
    S_ADDR,
    S_WGET,
    S_WSHIFT,
    S_RSHIFT,
    S_RPUT
  } mram_state_e;

endpackage

// File: rtl/mram_range_chk.sv
module mram_range_chk
  import spi_mram_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 16,
  parameter int CAP_BYTES = 524288,
  parameter int BLK_BYTES = 256
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  mram_op_e          op,
  output logic              fits
);
  localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 2;
  localparam logic [SUM_W-1:0] CAP_V = SUM_W'(CAP_BYTES);
  localparam logic [SUM_W-1:0] BLK_V = SUM_W'(BLK_BYTES);

  logic [SUM_W-1:0] start_w;
  logic [SUM_W-1:0] end_w;

  always_comb begin
    start_w = SUM_W'(addr);
    end_w   = start_w + ((op == OP_ERASE) ? BLK_V : SUM_W'(len));
    fits    = (start_w < CAP_V) && (end_w <= CAP_V);
  end
endmodule

// File: rtl/mram_sck_tick.sv
module mram_sck_tick #(
  parameter int SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SCK_HALF - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mram_byte_shift.sv
module mram_byte_shift #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx
);
  logic       active;
  logic       tick;
  logic [2:0] bit_idx;
  logic [7:0] sh;

  mram_sck_tick #(.SCK_HALF(SCK_HALF)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (active),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      sck       <= 1'b0;
      mosi      <= 1'b0;
      bit_idx   <= '0;
      sh        <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (start) begin
        active  <= 1'b1;
        sck     <= 1'b0;
        sh      <= tx;
        mosi    <= tx[7];
        bit_idx <= '0;
      end else if (tick) begin
        if (!sck) begin
          sck <= 1'b1;
          sh  <= {sh[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_idx == 3'd7) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            mosi    <= sh[7];
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end

  assign rx = sh;
endmodule

// File: rtl/spi_mram_ctrl.sv
module spi_mram_ctrl
  import spi_mram_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int LEN_W      = 16,
  parameter int CAP_BYTES  = 524288,
  parameter int BLK_BYTES  = 256,
  parameter int SCK_HALF   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [1:0]              req_op,
  input  logic [8*ADDR_BYTES-1:0] req_addr,
  input  logic [LEN_W-1:0]        req_len,
  output logic                    busy,
  output logic                    done,
  output logic                    done_ok,
  input  logic [7:0]              wr_data,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  output logic [7:0]              rd_data,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic                    spi_cs_n,
  output logic                    spi_sck,
  output logic                    spi_mosi,
  input  logic                    spi_miso
);
  localparam int ADDR_W  = 8 * ADDR_BYTES;
  localparam int GAP_CYC = 2 * SCK_HALF - 1;
  localparam int GAP_W   = $clog2(GAP_CYC + 1) + 1;
  localparam int IDX_W   = $clog2(ADDR_BYTES + 1);

  mram_state_e       state;
  mram_op_e          op_in;
  logic              fits;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [IDX_W-1:0]  idx_q;
  logic [GAP_W-1:0]  gap_q;
  logic              is_wr;
  logic              gap_to_wr;
  logic              sh_start;
  logic [7:0]        sh_tx;
  logic              sh_done;
  logic [7:0]        sh_rx;

  assign op_in = mram_op_e'(req_op);

  mram_range_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CAP_BYTES(CAP_BYTES), .BLK_BYTES(BLK_BYTES)
  ) u_range (
    .addr (req_addr),
    .len  (req_len),
    .op   (op_in),
    .fits (fits)
  );

  mram_byte_shift #(.SCK_HALF(SCK_HALF)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (sh_start),
    .tx        (sh_tx),
    .miso      (spi_miso),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .byte_done (sh_done),
    .rx        (sh_rx)
  );

  assign wr_ready = (state == S_WGET);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      spi_cs_n  <= 1'b1;
      busy      <= 1'b0;
      done      <= 1'b0;
      done_ok   <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      sh_start  <= 1'b0;
      sh_tx     <= '0;
      addr_q    <= '0;
      rem_q     <= '0;
      idx_q     <= '0;
      gap_q     <= '0;
      is_wr     <= 1'b0;
      gap_to_wr <= 1'b0;
    end else begin
      sh_start <= 1'b0;
      done     <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            busy   <= 1'b1;
            addr_q <= req_addr;
            rem_q  <= req_len;
            is_wr  <= (op_in == OP_WRITE);
            if (((op_in != OP_READ) && (op_in != OP_WRITE)) || !fits) begin
              done_ok <= fits && (op_in == OP_ERASE);
              state   <= S_FIN;
            end else begin
              done_ok  <= 1'b1;
              spi_cs_n <= 1'b0;
              sh_start <= 1'b1;
              if (op_in == OP_WRITE) begin
                sh_tx <= CMD_WR_ENABLE;
                state <= S_WREN;
              end else begin
                sh_tx <= CMD_READ;
                state <= S_CMD;
              end
            end
          end
        end
        S_FIN: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        S_WREN: begin
          if (sh_done) begin
            spi_cs_n  <= 1'b1;
            gap_q     <= GAP_W'(GAP_CYC);
            gap_to_wr <= 1'b1;
            state     <= S_GAP;
          end
        end
        S_GAP: begin
          if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
          end else if (gap_to_wr) begin
            gap_to_wr <= 1'b0;
            spi_cs_n  <= 1'b0;
            sh_start  <= 1'b1;
            sh_tx     <= CMD_WRITE;
            state     <= S_CMD;
          end else begin
            state <= S_FIN;
          end
        end
        S_CMD: begin
          if (sh_done) begin
            sh_start <= 1'b1;
            sh_tx    <= addr_q[ADDR_W-1 -: 8];
            addr_q   <= addr_q << 8;
            idx_q    <= IDX_W'(ADDR_BYTES - 1);
            state    <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (sh_done) begin
            if (idx_q != '0) begin
              sh_start <= 1'b1;
              sh_tx    <= addr_q[ADDR_W-1 -: 8];
              addr_q   <= addr_q << 8;
              idx_q    <= idx_q - 1'b1;
            end else if (rem_q == '0) begin
              spi_cs_n <= 1'b1;
              gap_q    <= GAP_W'(GAP_CYC);
              state    <= S_GAP;
            end else if (is_wr) begin
              state <= S_WGET;
            end else begin
              sh_start <= 1'b1;
              sh_tx    <= RD_FILLER;
              state    <= S_RSHIFT;
            end
          end
        end
        S_WGET: begin
          if (wr_valid) begin
            sh_start <= 1'b1;
            sh_tx    <= wr_data;
            rem_q    <= rem_q - 1'b1;
            state    <= S_WSHIFT;
          end
        end
        S_WSHIFT: begin
          if (sh_done) begin
            if (rem_q == '0) begin
              spi_cs_n <= 1'b1;
              gap_q    <= GAP_W'(GAP_CYC);
              state    <= S_GAP;
            end else begin
              state <= S_WGET;
            end
          end
        end
        S_RSHIFT: begin
          if (sh_done) begin
            rd_data  <= sh_rx;
            rd_valid <= 1'b1;
            rem_q    <= rem_q - 1'b1;
            state    <= S_RPUT;
          end
        end
        S_RPUT: begin
          if (rd_ready) begin
            rd_valid <= 1'b0;
            if (rem_q == '0) begin
              spi_cs_n <= 1'b1;
              gap_q    <= GAP_W'(GAP_CYC);
              state    <= S_GAP;
            end else begin
              sh_start <= 1'b1;
              sh_tx    <= RD_FILLER;
              state    <= S_RSHIFT;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_mram_ctrl_chk.sv
module spi_mram_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       wr_ready,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi
);
  // R6
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  // R6
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2
  frame_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> busy);

  // R10
  wr_ready_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> !spi_cs_n);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R10
  rd_stall_sck_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !spi_sck);
endmodule

bind spi_mram_ctrl spi_mram_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .wr_ready (wr_ready),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .spi_cs_n (spi_cs_n),
  .spi_sck  (spi_sck),
  .spi_mosi (spi_mosi)
);

// File: tb/spi_mram_ctrl_test.sv
module spi_mram_ctrl_test;
  localparam int HALF = 2;
  localparam int PER  = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        busy, done, done_ok;
  logic [7:0]  wr_data = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;

  always #(PER/2) clk = ~clk;

  spi_mram_ctrl #(.SCK_HALF(HALF)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
    .done_ok(done_ok), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int fails  = 0;
  int ndone  = 0;
  int cyc    = 0;
  bit bp_en  = 1'b0;
  bit finished = 1'b0;

  task automatic chk(bit cond, string req, string what, int act, int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7) + 3);
  endfunction

  // Device model: records frame bytes, -1 marks a frame end
  int log_q[$];
  int bitn = 0, nbytes = 0, opc = 0, saddr = 0;
  logic [7:0] acc = '0;

  always @(negedge spi_cs_n) begin
    bitn = 0; nbytes = 0; opc = 0; saddr = 0; acc = '0;
  end
  always @(posedge spi_cs_n) if (!rst) log_q.push_back(-1);

  always @(posedge spi_sck) if (!rst) begin
    acc = {acc[6:0], spi_mosi};
    bitn++;
    if (bitn == 8) begin
      log_q.push_back(int'(acc));
      if (nbytes == 0) opc = int'(acc);
      else if (nbytes <= 3) saddr = (saddr << 8) | int'(acc);
      nbytes++;
      bitn = 0;
    end
  end

  always @(negedge spi_sck) if (!rst) begin
    if (opc == 3 && nbytes >= 4) begin
      logic [7:0] b;
      b = pat(saddr + nbytes - 4);
      spi_miso <= b[7 - bitn];
    end else begin
      spi_miso <= 1'b0;
    end
  end

  // Timing reference: SCK high phase and CS gap, R7 and R8
  time t_rise = 0, t_csrise = 0;
  always @(posedge spi_sck) t_rise = $time;
  always @(negedge spi_sck) if (!rst && t_rise != 0)
    chk(($time - t_rise) == HALF * PER, "R7", "sck high time", int'($time - t_rise), HALF * PER);
  always @(posedge spi_cs_n) if (!rst) t_csrise = $time;
  always @(negedge spi_cs_n) if (!rst && t_csrise != 0)
    chk(($time - t_csrise) >= 2 * HALF * PER, "R8", "cs high gap", int'($time - t_csrise), 2 * HALF * PER);

  // Per-clock reference comparison
  always @(negedge clk) if (!rst) begin
    cyc++;
    chk(!(spi_cs_n && spi_sck), "R6", "sck while deselected", int'(spi_sck), 0);
    chk(!(done && busy), "R9", "busy during done", int'(busy), 0);
    chk(!(wr_ready && spi_cs_n), "R10", "wr_ready outside frame", int'(wr_ready), 0);
    chk(!(rd_valid && spi_sck), "R10", "sck while read byte pending", int'(spi_sck), 0);
  end
  always @(posedge clk) if (!rst && done) ndone++;

  // Write payload source
  int wq[$];
  bit wr_hs = 1'b0;
  always @(posedge clk) if (wr_valid && wr_ready) wr_hs = 1'b1;
  always @(negedge clk) begin
    if (wr_hs) begin
      void'(wq.pop_front());
      wr_hs = 1'b0;
    end
    wr_valid = (wq.size() > 0);
    wr_data  = wr_valid ? 8'(wq[0]) : 8'h00;
  end

  // Read sink with optional backpressure
  int rdq[$];
  always @(posedge clk) if (!rst && rd_valid && rd_ready) rdq.push_back(int'(rd_data));
  always @(negedge clk) rd_ready = bp_en ? ((cyc % 3) == 0) : 1'b1;

  task automatic expect_log(string req, int exp[$]);
    chk(log_q.size() == exp.size(), req, "bus byte count", log_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < log_q.size(); i++)
      chk(log_q[i] == exp[i], req, "bus byte", log_q[i], exp[i]);
    log_q.delete();
  endtask

  task automatic expect_rd(string req, int base, int n);
    chk(rdq.size() == n, req, "read byte count", rdq.size(), n);
    for (int i = 0; i < n && i < rdq.size(); i++)
      chk(rdq[i] == int'(pat(base + i)), req, "read byte", rdq[i], int'(pat(base + i)));
    rdq.delete();
  endtask

  task automatic run_req(int op, int addr, int len, output bit ok);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_op = 2'(op); req_addr = 24'(addr); req_len = 16'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    ok = done_ok;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    summary();
  end

  initial begin
    bit ok;
    int e[$];
    int d0;

    // R1 reset state
    repeat (4) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1", "bus idle in reset", int'({spi_cs_n, spi_sck}), 2);
    chk(!busy && !done && !rd_valid && !wr_ready, "R1", "status in reset",
        int'({busy, done, rd_valid, wr_ready}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(spi_cs_n == 1'b1 && !busy && !done, "R1", "idle after reset", int'({spi_cs_n, busy, done}), 4);

    // R4 write, two frames
    wq = '{8'hA1, 8'hB2, 8'hC3};
    run_req(1, 24'h012345, 3, ok);
    chk(ok, "R4", "write status", int'(ok), 1);
    e = '{6, -1, 2, 8'h01, 8'h23, 8'h45, 8'hA1, 8'hB2, 8'hC3, -1};
    expect_log("R4", e);

    // R5 read with backpressure; R9 stray strobe while busy
    bp_en = 1'b1;
    d0 = ndone;
    fork
      run_req(0, 24'h07FF00, 4, ok);
      begin
        repeat (30) @(negedge clk);
        req_op = 2'd2; req_addr = 24'h0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    bp_en = 1'b0;
    chk(ok, "R5", "read status", int'(ok), 1);
    e = '{3, 8'h07, 8'hFF, 8'h00, 0, 0, 0, 0, -1};
    expect_log("R5", e);
    expect_rd("R5", 24'h07FF00, 4);
    repeat (5) @(negedge clk);
    chk((ndone - d0) == 1, "R9", "done count with stray strobe", ndone - d0, 1);

    // R2 refused: end beyond capacity, start at capacity
    run_req(0, 24'h07FFFE, 3, ok);
    chk(!ok, "R2", "overrun read refused", int'(ok), 0);
    run_req(1, 24'h080000, 0, ok);
    chk(!ok, "R2", "write at capacity refused", int'(ok), 0);
    e.delete();
    expect_log("R2", e);

    // R2 boundary accepted: last byte
    run_req(0, 24'h07FFFF, 1, ok);
    chk(ok, "R2", "last byte read accepted", int'(ok), 1);
    e = '{3, 8'h07, 8'hFF, 8'hFF, 0, -1};
    expect_log("R2", e);
    expect_rd("R2", 24'h07FFFF, 1);

    // R3 erase
    run_req(2, 24'h07FF00, 0, ok);
    chk(ok, "R3", "erase of top block", int'(ok), 1);
    run_req(2, 24'h07FF01, 0, ok);
    chk(!ok, "R3", "erase straddling end", int'(ok), 0);
    e.delete();
    expect_log("R3", e);

    // R5 zero-length read
    run_req(0, 24'h000100, 0, ok);
    chk(ok, "R5", "zero length read status", int'(ok), 1);
    e = '{3, 8'h00, 8'h01, 8'h00, -1};
    expect_log("R5", e);
    expect_rd("R5", 0, 0);

    // R9 done and next accept in the same cycle
    wq = '{8'h5A};
    @(negedge clk);
    req_op = 2'd1; req_addr = 24'h000010; req_len = 16'd1; req_valid = 1'b1;
    @(negedge clk);
    while (!done) @(negedge clk);
    chk(done_ok, "R9", "first of pair status", int'(done_ok), 1);
    req_op = 2'd0; req_addr = 24'h000020; req_len = 16'd2;
    @(negedge clk);
    chk(busy && !done, "R9", "accepted in done cycle", int'({busy, done}), 2);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(done_ok, "R9", "second of pair status", int'(done_ok), 1);
    @(negedge clk);
    e = '{6, -1, 2, 0, 0, 8'h10, 8'h5A, -1, 3, 0, 0, 8'h20, 0, 0, -1};
    expect_log("R4", e);
    expect_rd("R5", 24'h000020, 2);

    summary();
  end
endmodule